// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small 8-bit processor core. It gathers request pulses from six peripheral sources into pending flags. It gates each flag with its own enable and a global enable. At each instruction-cycle boundary strobe, it gives the core a call request with a fixed vector address for the most urgent eligible source. The enables and flags live in two byte-wide registers that the core reads and writes through a one-bit register select.

Taking an interrupt has two side effects: it clears the serviced source's pending flag and it clears the global enable, so interrupts do not nest. The interrupt-return strobe turns the global enable back on. The plain return strobe does not. No vector is issued while the call stack reports full. The record source can only win while its converter is powered and its clock runs. The serial source can only win while the serial block is enabled.

Top module: `prio_intc`

## Requirements
- R1: After reset, both registers read 0x00, `vec_valid` is 0 and `vec_addr` is 0x00.
- R2: With `reg_sel`=0, `rd_data` shows global enable at bit 0, the enables of sources 0..2 at bits 1..3 and their flags at bits 4..6. With `reg_sel`=1, it shows the enables of sources 3..5 at bits 0..2 and their flags at bits 4..6. Unused bits (bit 7, and bit 3 of register 1) read 0.
- R3: A cycle with `wr_en`=1 loads the fields of the selected register from `wr_data` at the same bit positions. Values written to unused bits are discarded.
- R4: `src_req[i]`=1 sets flag i at the next edge. This takes precedence over a write or an acknowledge that clears flag i in the same cycle.
- R5: A vector is taken only in a cycle with `cycle_strobe`=1. `vec_valid` is a single-cycle pulse one clock later. Requests pending between strobes wait for the next strobe.
- R6: A source is eligible only if global enable, its enable and its flag are all 1.
- R7: Among eligible sources, the lowest index wins: 0 USB, 1 timer 0, 2 timer 1, 3 play, 4 serial, 5 record. Source i gets vector 0x04 + 4*i (0x04 to 0x18).
- R8: Taking a vector clears the winner's flag and the global enable at the same edge on which `vec_valid` rises. Other flags are kept, so no second vector follows until the global enable is set again.
- R9: While `stack_full`=1 at a strobe, no vector is taken and no flag or enable changes because of that strobe.
- R10: `reti_strobe`=1 sets the global enable at the next edge, overriding an acknowledge or write in that cycle. `ret_strobe` alone leaves it unchanged.
- R11: Source 5 (record) is not eligible while `adc_pwrdn`=1 or `usb_clk_en`=0. Its flag stays pending.
- R12: Source 4 (serial) is not eligible while `serial_blk_en`=0. Its flag stays pending.
- R13: `vec_addr` keeps the last issued vector until the next one is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register select for read and write (0 or 1) |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Contents of the selected register |
| src_req | input | 6 | Request pulses, one per source, index = priority rank |
| cycle_strobe | input | 1 | Instruction-cycle boundary strobe |
| stack_full | input | 1 | Call stack has no free entry |
| reti_strobe | input | 1 | Core executed an interrupt return |
| ret_strobe | input | 1 | Core executed a plain return |
| adc_pwrdn | input | 1 | Record converter powered down |
| usb_clk_en | input | 1 | USB clock running |
| serial_blk_en | input | 1 | Serial block enabled |
| vec_valid | output | 1 | One-cycle call request |
| vec_addr | output | 8 | Vector address of the last call request |

## Verification
The bench first sets all six flags at once and then grants them one at a time with an interrupt return between each. This checks that the vector order follows rank and that a second strobe without a return gives nothing. Directed sequences then hold a single source blocked by stack-full, by a missing enable, or by its power, clock or serial-block condition, and release it afterwards. Each sequence shows whether the blocking left the flag pending. A long random stream then mixes writes, requests, strobes and both return kinds in the same cycles. Against a behavioural model, this tests the order in which clears and sets combine.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int NSRC   = 6;
    localparam int BANK   = 3;           // sources per register
    localparam int ADDR_W = 8;
    localparam int SRC_SER = 4;
    localparam int SRC_REC = 5;

    typedef struct packed {
        logic              gie;
        logic [NSRC-1:0]   en;
        logic [NSRC-1:0]   flag;
        logic              vec_valid;
        logic [ADDR_W-1:0] vec_addr;
    } intc_state_t;
endpackage

// File: rtl/intc_eligible.sv
module intc_eligible
    import intc_pkg::*;
(
    input  logic            gie,
    input  logic [NSRC-1:0] en,
    input  logic [NSRC-1:0] flag,
    input  logic            adc_pwrdn,
    input  logic            usb_clk_en,
    input  logic            serial_blk_en,
    output logic [NSRC-1:0] elig
);
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic side_ok;
        if (g == SRC_REC) begin : g_rec
            assign side_ok = !adc_pwrdn && usb_clk_en;
        end else if (g == SRC_SER) begin : g_ser
            assign side_ok = serial_blk_en;
        end else begin : g_plain
            assign side_ok = 1'b1;
        end
        assign elig[g] = gie && en[g] && flag[g] && side_ok;
    end
endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
    parameter int N      = 6,
    parameter int ADDR_W = 8,
    parameter int BASE   = 4,
    parameter int STEP   = 4
) (
    input  logic [N-1:0]      req,
    output logic              hit,
    output logic [N-1:0]      grant,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        hit   = 1'b0;
        grant = '0;
        addr  = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !hit) begin
                hit      = 1'b1;
                grant[i] = 1'b1;
                addr     = ADDR_W'(BASE + STEP * i);
            end
        end
    end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import intc_pkg::*;
#(
    parameter int VEC_BASE = 4,
    parameter int VEC_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic [NSRC-1:0]   src_req,
    input  logic              cycle_strobe,
    input  logic              stack_full,
    input  logic              reti_strobe,
    input  logic              ret_strobe,
    input  logic              adc_pwrdn,
    input  logic              usb_clk_en,
    input  logic              serial_blk_en,
    output logic              vec_valid,
    output logic [ADDR_W-1:0] vec_addr
);
    localparam logic [ADDR_W-1:0] REC_ADDR = ADDR_W'(VEC_BASE + VEC_STEP * SRC_REC);
    localparam int HI = NSRC - 1;

    intc_state_t state_d, state_q;

    logic [NSRC-1:0]   elig;
    logic [NSRC-1:0]   grant;
    logic              any_elig;
    logic [ADDR_W-1:0] pick_addr;
    logic              take;

    intc_eligible i_elig (
        .gie           (state_q.gie),
        .en            (state_q.en),
        .flag          (state_q.flag),
        .adc_pwrdn     (adc_pwrdn),
        .usb_clk_en    (usb_clk_en),
        .serial_blk_en (serial_blk_en),
        .elig          (elig)
    );

    intc_prio_pick #(
        .N      (NSRC),
        .ADDR_W (ADDR_W),
        .BASE   (VEC_BASE),
        .STEP   (VEC_STEP)
    ) i_pick (
        .req   (elig),
        .hit   (any_elig),
        .grant (grant),
        .addr  (pick_addr)
    );

    assign take = cycle_strobe && !stack_full && any_elig;

    always_comb begin
        state_d           = state_q;
        state_d.vec_valid = 1'b0;
        // software write comes first
        if (wr_en) begin
            if (!reg_sel) begin
                state_d.gie            = wr_data[0];
                state_d.en[BANK-1:0]   = wr_data[BANK:1];
                state_d.flag[BANK-1:0] = wr_data[BANK+3:4];
            end else begin
                state_d.en[HI:BANK]    = wr_data[BANK-1:0];
                state_d.flag[HI:BANK]  = wr_data[BANK+3:4];
            end
        end
        // acknowledge overrides the write
        if (take) begin
            state_d.flag      = state_d.flag & ~grant;
            state_d.gie       = 1'b0;
            state_d.vec_valid = 1'b1;
            state_d.vec_addr  = pick_addr;
        end
        // interrupt return re-arms
        if (reti_strobe) begin
            state_d.gie = 1'b1;
        end
        // hardware requests win over every clear
        state_d.flag = state_d.flag | src_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        if (!reg_sel) begin
            rd_data = {1'b0, state_q.flag[BANK-1:0], state_q.en[BANK-1:0], state_q.gie};
        end else begin
            rd_data = {1'b0, state_q.flag[HI:BANK], 1'b0, state_q.en[HI:BANK]};
        end
    end

    assign vec_valid = state_q.vec_valid;
    assign vec_addr  = state_q.vec_addr;

    AST_STROBE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle_strobe |=> !vec_valid); // R5
    AST_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_strobe && !state_q.gie |=> !vec_valid); // R6
    AST_ACK_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid && !$past(reti_strobe) |-> !state_q.gie); // R8
    AST_STACK_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_strobe && stack_full |=> !vec_valid); // R9
    AST_RETI_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        reti_strobe |=> state_q.gie); // R10
    AST_RET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        ret_strobe && !reti_strobe && !wr_en && !cycle_strobe
        |=> state_q.gie == $past(state_q.gie)); // R10
    AST_REC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid && vec_addr == REC_ADDR |-> $past(usb_clk_en && !adc_pwrdn)); // R11
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> $stable(vec_addr)); // R13

    for (genvar g = 0; g < NSRC; g++) begin : g_req_chk
        AST_REQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            src_req[g] |=> state_q.flag[g]); // R4
    end
endmodule

// File: tb/test_prio_intc.sv
module test_prio_intc;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_sel = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [5:0] src_req = '0;
    logic       cycle_strobe = 1'b0, stack_full = 1'b0;
    logic       reti_strobe = 1'b0, ret_strobe = 1'b0;
    logic       adc_pwrdn = 1'b0, usb_clk_en = 1'b1, serial_blk_en = 1'b1;
    logic       vec_valid;
    logic [7:0] vec_addr;

    int errors = 0;
    int checks = 0;

    // reference state
    bit       m_gie;
    bit [5:0] m_en, m_flag;
    bit       m_vv;
    bit [7:0] m_va;

    always #5 clk = ~clk;

    prio_intc i_prio_intc (
        .clk, .rst_n, .reg_sel, .wr_en, .wr_data, .rd_data, .src_req,
        .cycle_strobe, .stack_full, .reti_strobe, .ret_strobe,
        .adc_pwrdn, .usb_clk_en, .serial_blk_en, .vec_valid, .vec_addr
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit [7:0] m_reg(input bit sel);
        if (!sel) return {1'b0, m_flag[2:0], m_en[2:0], m_gie};
        return {1'b0, m_flag[5:3], 1'b0, m_en[5:3]};
    endfunction

    // one clock: model step, edge, compare at the following negedge
    task automatic tick(input string tag);
        bit [5:0] nf, ne;
        bit ng, nv;
        bit [7:0] na;
        int win;
        win = -1;
        if (cycle_strobe && !stack_full) begin
            for (int i = 5; i >= 0; i--) begin
                bit ok;
                ok = m_gie && m_en[i] && m_flag[i];
                if (i == 4 && !serial_blk_en) ok = 0;
                if (i == 5 && (adc_pwrdn || !usb_clk_en)) ok = 0;
                if (ok) win = i;
            end
        end
        ng = m_gie; ne = m_en; nf = m_flag; nv = 0; na = m_va;
        if (wr_en) begin
            if (!reg_sel) begin
                ng = wr_data[0];
                for (int i = 0; i < 3; i++) begin ne[i] = wr_data[1+i]; nf[i] = wr_data[4+i]; end
            end else begin
                for (int i = 0; i < 3; i++) begin ne[3+i] = wr_data[i]; nf[3+i] = wr_data[4+i]; end
            end
        end
        if (win >= 0) begin
            nf[win] = 0; ng = 0; nv = 1; na = 8'(4 + 4 * win);
        end
        if (reti_strobe) ng = 1;
        nf = nf | src_req;
        @(posedge clk);
        m_gie = ng; m_en = ne; m_flag = nf; m_vv = nv; m_va = na;
        @(negedge clk);
        chk({tag, " vec_valid"}, int'(vec_valid), int'(m_vv));
        chk({tag, " vec_addr"}, int'(vec_addr), int'(m_va));
        chk({tag, " rd_data"}, int'(rd_data), int'(m_reg(reg_sel)));
        wr_en = 0; src_req = '0; cycle_strobe = 0; reti_strobe = 0; ret_strobe = 0;
    endtask

    task automatic rd(input bit sel, output bit [7:0] v);
        reg_sel = sel; #1; v = rd_data;
    endtask

    task automatic wr(input bit sel, input bit [7:0] d, input string tag);
        reg_sel = sel; wr_en = 1; wr_data = d; tick(tag);
    endtask

    task automatic strobe(input string tag);
        cycle_strobe = 1; tick(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit [7:0] v;
        m_gie = 0; m_en = '0; m_flag = '0; m_vv = 0; m_va = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(0, v); chk("R1 reg0", v, 0);
        rd(1, v); chk("R1 reg1", v, 0);
        chk("R1 vec_valid", vec_valid, 0);
        chk("R1 vec_addr", vec_addr, 0);

        // R2 R3 layout and unused bits
        wr(0, 8'hFF, "R3 write0");
        rd(0, v); chk("R2 reg0 unused bit7", v, 8'h7F);
        wr(1, 8'hFF, "R3 write1");
        rd(1, v); chk("R2 reg1 unused bits", v, 8'h77);
        wr(0, 8'h00, "R3 clear0");
        wr(1, 8'h00, "R3 clear1");

        // enable everything, raise all six requests
        wr(0, 8'h0F, "R3 en0");
        wr(1, 8'h07, "R3 en1");
        src_req = 6'h3F; tick("R4 set all");
        for (int k = 0; k < 3; k++) begin
            tick("R5 wait");
            chk("R5 no vector between strobes", vec_valid, 0);
        end
        strobe("R7 first");
        chk("R7 highest wins", vec_addr, 8'h04);
        rd(0, v); chk("R8 flag0 and gie cleared", v, 8'h6E);
        strobe("R8 no nest");
        chk("R8 no second vector", vec_valid, 0);
        for (int k = 1; k < 6; k++) begin
            reti_strobe = 1; tick("R10 reti");
            strobe("R7 next");
            chk("R7 priority order", vec_addr, 4 + 4 * k);
        end
        tick("R13 idle");
        chk("R13 addr held", vec_addr, 8'h18);
        chk("R13 valid single pulse", vec_valid, 0);

        // R9 stack full
        reti_strobe = 1; tick("R10 reti");
        src_req = 6'h02; tick("R4 t0 req");
        stack_full = 1; strobe("R9 blocked");
        chk("R9 no vector when full", vec_valid, 0);
        rd(0, v); chk("R9 state kept", v, 8'h2F);
        stack_full = 0; strobe("R9 release");
        chk("R9 vector after release", vec_addr, 8'h08);

        // R10 plain return
        ret_strobe = 1; tick("R10 ret");
        rd(0, v); chk("R10 ret keeps gie off", v[0], 0);
        reti_strobe = 1; tick("R10 reti");
        rd(0, v); chk("R10 reti sets gie", v[0], 1);

        // R11 record gating
        src_req = 6'h20; tick("R4 rec req");
        adc_pwrdn = 1; strobe("R11 pwrdn");
        chk("R11 blocked by power-down", vec_valid, 0);
        adc_pwrdn = 0; usb_clk_en = 0; strobe("R11 clk off");
        chk("R11 blocked by clock", vec_valid, 0);
        rd(1, v); chk("R11 flag pending", v[6], 1);
        usb_clk_en = 1; strobe("R11 release");
        chk("R11 vector", vec_addr, 8'h18);

        // R12 serial gating
        reti_strobe = 1; tick("R10 reti");
        src_req = 6'h10; tick("R4 ser req");
        serial_blk_en = 0; strobe("R12 off");
        chk("R12 blocked", vec_valid, 0);
        serial_blk_en = 1; strobe("R12 on");
        chk("R12 vector", vec_addr, 8'h14);

        // R6 source enable required
        wr(0, 8'h0B, "R6 t0 disabled");
        src_req = 6'h02; tick("R4 t0 req");
        strobe("R6 strobe");
        chk("R6 disabled source ignored", vec_valid, 0);
        wr(0, 8'h2E, "R6 gie off");
        strobe("R6 gie off strobe");
        chk("R6 no vector without gie", vec_valid, 0);

        // R4 request beats a clearing write
        reg_sel = 0; wr_en = 1; wr_data = 8'h00; src_req = 6'h01; tick("R4 race");
        rd(0, v); chk("R4 request wins over write", v, 8'h10);

        // random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            reg_sel       = 1'($urandom_range(0, 1));
            wr_en         = ($urandom_range(0, 15) == 0);
            wr_data       = 8'($urandom);
            for (int i = 0; i < 6; i++) src_req[i] = ($urandom_range(0, 9) == 0);
            cycle_strobe  = ($urandom_range(0, 3) == 0);
            stack_full    = ($urandom_range(0, 7) == 0);
            reti_strobe   = ($urandom_range(0, 9) == 0);
            ret_strobe    = ($urandom_range(0, 9) == 0);
            adc_pwrdn     = ($urandom_range(0, 5) == 0);
            usb_clk_en    = ($urandom_range(0, 5) != 0);
            serial_blk_en = ($urandom_range(0, 5) != 0);
            tick("R7 R8 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule